// File: doc/BRIEF.md
# Ternary Row Update Controller

This controller sits beside a one-transistor one-resistor crossbar that learns on its own. It turns a single learning event into one write of one row. A learning event carries a row address, an update strobe and a polarity bit. When the addressed row is currently eligible, the controller latches three things at the moment it accepts the event: the row, the polarity and the binarized presynaptic bit of every column. It then holds a write for a programmable number of clock cycles.

During that write, only the selected word line stays on. Each column whose latched bit is set receives the set select when the polarity is 0 or the reset select when the polarity is 1. Every other column stays idle. A one-cycle acknowledge marks the end of the write.

When the addressed row is not eligible, the event is acknowledged at once and nothing is written. While a write is in progress, incoming inference events are refused and further learning events are ignored.

Top module: `tru_ctrl`

## Requirements
- R1: After reset the block is in inference mode. Every row learn bit and every column select is 0, all word-line enables are 1, and the acknowledge is 0.
- R2: A strobe on `upd_stb_i` at a clock edge, with `elig_i[upd_addr_i]` = 1 and the block idle, starts a write from the next cycle. In that write `row_lrn_o` is one-hot on bit `upd_addr_i`.
- R3: A strobe addressed to a row whose eligibility bit is 0, or to an address of `NUM_ROWS` or above, writes nothing. It raises `ack_o` for exactly one cycle, in the cycle after the strobe edge.
- R4: During a write, a column whose latched trace bit is 1 gets `col_set_o` = 1 when the latched polarity is 0, or `col_rst_o` = 1 when it is 1. All other columns have both selects at 0. Set and reset are never active together within one write.
- R5: The polarity and the trace bits are sampled only at the edge that accepts the strobe. Later changes on `upd_neg_i`, `trace_i` or `elig_i` do not alter a write that is already running.
- R6: During a write, `wl_en_o` equals `row_lrn_o`. In inference mode, `wl_en_o` is all ones.
- R7: A write lasts `pulse_len_i` cycles as sampled at the accepting edge, with a value of 0 treated as 1. In the following cycle all selects are idle and `ack_o` is 1 for exactly one cycle.
- R8: Learning strobes that arrive while a write is running are ignored. The running write keeps its row, its length and its column selects.
- R9: `inf_ack_o` equals `inf_vld_i` in inference mode and is 0 while `lrn_mode_o` is 1.
- R10: `lrn_mode_o` is 1 exactly when some bit of `row_lrn_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_stb_i | input | 1 | Learning event strobe (update request) |
| upd_addr_i | input | ADDR_W | Row address of the learning event |
| upd_neg_i | input | 1 | Polarity: 0 = increase conductance, 1 = decrease |
| elig_i | input | NUM_ROWS | Per-row eligibility bits (membrane inside the learning window) |
| trace_i | input | NUM_COLS | Per-column binarized presynaptic trace |
| pulse_len_i | input | CNT_W | Write pulse length in cycles (0 acts as 1) |
| inf_vld_i | input | 1 | Incoming inference event |
| inf_ack_o | output | 1 | Inference event accepted |
| row_lrn_o | output | NUM_ROWS | Per-row learn signals |
| lrn_mode_o | output | 1 | 1 = weight update, 0 = inference |
| wl_en_o | output | NUM_ROWS | Word-line enables |
| col_set_o | output | NUM_COLS | Per-column set-voltage select |
| col_rst_o | output | NUM_COLS | Per-column reset-voltage select |
| ack_o | output | 1 | One-cycle completion acknowledge |

## Verification
The assertions assume that the strobe, the polarity, the eligibility bits, the traces and the pulse length are stable and valid at the sampling edge. They place no other constraint on the inputs. In particular, they do not assume that strobes are spaced apart, because extra strobes during a write must be ignored.

The stimulus drives every input on the falling edge. It changes traces, eligibility and polarity freely once a strobe has been taken. During writes it injects stray strobes with random addresses, and it mixes random events with directed cases: length 0, length 1, the top row, an ineligible row, all-zero traces and all-one traces.

// File: rtl/tru_pkg.sv
package tru_pkg;
  typedef enum logic {
    TRU_IDLE  = 1'b0,
    TRU_WRITE = 1'b1
  } tru_state_e;
endpackage

// File: rtl/tru_row_sel.sv
module tru_row_sel #(
  parameter int NUM_ROWS = 8,
  parameter int ADDR_W   = $clog2(NUM_ROWS)
) (
  input  logic                stb_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_ROWS-1:0] elig_i,
  output logic [NUM_ROWS-1:0] sel_o
);
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign sel_o[r] = stb_i & elig_i[r] & (addr_i == ADDR_W'(r));
  end
endmodule

// File: rtl/tru_col_drv.sv
module tru_col_drv #(
  parameter int NUM_COLS = 8
) (
  input  logic                active_i,
  input  logic                neg_i,
  input  logic [NUM_COLS-1:0] trace_i,
  output logic [NUM_COLS-1:0] set_o,
  output logic [NUM_COLS-1:0] rst_o
);
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign set_o[c] = active_i & ~neg_i & trace_i[c];
    assign rst_o[c] = active_i &  neg_i & trace_i[c];
  end
endmodule

// File: rtl/tru_pulse_tmr.sv
module tru_pulse_tmr
  import tru_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             skip_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  tru_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TRU_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        TRU_IDLE: begin
          if (start_i) begin
            cnt_q   <= (len_i == '0) ? ONE : len_i;
            state_q <= TRU_WRITE;
          end else if (skip_i) begin
            done_q <= 1'b1;
          end
        end
        TRU_WRITE: begin
          if (cnt_q == ONE) begin
            state_q <= TRU_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        default: state_q <= TRU_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == TRU_WRITE);
  assign done_o = done_q;

  // R7
  last_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q == ONE) |=> (!busy_o && done_o));

  // R7
  cnt_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q != '0));
endmodule

// File: rtl/tru_ctrl.sv
module tru_ctrl #(
  parameter int NUM_ROWS = 8,
  parameter int NUM_COLS = 8,
  parameter int CNT_W    = 8,
  localparam int ADDR_W  = $clog2(NUM_ROWS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_stb_i,
  input  logic [ADDR_W-1:0]   upd_addr_i,
  input  logic                upd_neg_i,
  input  logic [NUM_ROWS-1:0] elig_i,
  input  logic [NUM_COLS-1:0] trace_i,
  input  logic [CNT_W-1:0]    pulse_len_i,
  input  logic                inf_vld_i,
  output logic                inf_ack_o,
  output logic [NUM_ROWS-1:0] row_lrn_o,
  output logic                lrn_mode_o,
  output logic [NUM_ROWS-1:0] wl_en_o,
  output logic [NUM_COLS-1:0] col_set_o,
  output logic [NUM_COLS-1:0] col_rst_o,
  output logic                ack_o
);
  logic [NUM_ROWS-1:0] sel;
  logic [NUM_ROWS-1:0] row_q;
  logic [NUM_COLS-1:0] trace_q;
  logic neg_q, busy, start, skip;

  tru_row_sel #(.NUM_ROWS(NUM_ROWS), .ADDR_W(ADDR_W)) row_sel_i (
    .stb_i (upd_stb_i),
    .addr_i(upd_addr_i),
    .elig_i(elig_i),
    .sel_o (sel)
  );

  assign start = ~busy & (|sel);
  assign skip  = ~busy & upd_stb_i & ~(|sel);

  tru_pulse_tmr #(.CNT_W(CNT_W)) tmr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .skip_i (skip),
    .len_i  (pulse_len_i),
    .busy_o (busy),
    .done_o (ack_o)
  );

  // trace bits are captured only when an update is accepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q   <= '0;
      trace_q <= '0;
      neg_q   <= 1'b0;
    end else if (start) begin
      row_q   <= sel;
      trace_q <= trace_i;
      neg_q   <= upd_neg_i;
    end
  end

  assign row_lrn_o  = busy ? row_q : '0;
  assign lrn_mode_o = |row_lrn_o;
  assign wl_en_o    = lrn_mode_o ? row_lrn_o : '1;
  assign inf_ack_o  = inf_vld_i & ~lrn_mode_o;

  tru_col_drv #(.NUM_COLS(NUM_COLS)) col_drv_i (
    .active_i(lrn_mode_o),
    .neg_i   (neg_q),
    .trace_i (trace_q),
    .set_o   (col_set_o),
    .rst_o   (col_rst_o)
  );

  // R2
  one_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_lrn_o));

  // R4
  single_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|col_set_o) && (|col_rst_o)));

  // R5
  hold_cols_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrn_mode_o && $past(lrn_mode_o)) |-> ($stable(col_set_o) && $stable(col_rst_o)));

  // R6
  wl_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lrn_mode_o |-> (wl_en_o == row_lrn_o));

  // R9
  inf_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inf_ack_o |-> !lrn_mode_o);

  // R7
  end_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lrn_mode_o) |-> (ack_o && col_set_o == '0 && col_rst_o == '0));

  // R3
  ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !lrn_mode_o);
endmodule

// File: tb/tru_ctrl_tb.sv
module tru_ctrl_tb_top;
  localparam int NR = 8;
  localparam int NC = 8;
  localparam int CW = 8;
  localparam int AW = $clog2(NR);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_stb = 1'b0;
  logic [AW-1:0] upd_addr = '0;
  logic upd_neg = 1'b0;
  logic [NR-1:0] elig = '0;
  logic [NC-1:0] trace = '0;
  logic [CW-1:0] plen = '0;
  logic inf_vld = 1'b0;
  logic inf_ack, lrn_mode, ack;
  logic [NR-1:0] row_lrn, wl_en;
  logic [NC-1:0] cset, crst;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tru_ctrl #(.NUM_ROWS(NR), .NUM_COLS(NC), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .upd_stb_i(upd_stb), .upd_addr_i(upd_addr),
    .upd_neg_i(upd_neg), .elig_i(elig), .trace_i(trace), .pulse_len_i(plen),
    .inf_vld_i(inf_vld), .inf_ack_o(inf_ack), .row_lrn_o(row_lrn),
    .lrn_mode_o(lrn_mode), .wl_en_o(wl_en), .col_set_o(cset), .col_rst_o(crst),
    .ack_o(ack)
  );

  function automatic logic [NC-1:0] exp_set(logic [NC-1:0] tr, logic neg);
    return neg ? '0 : tr;
  endfunction

  function automatic logic [NC-1:0] exp_rst(logic [NC-1:0] tr, logic neg);
    return neg ? tr : '0;
  endfunction

  function automatic int eff_len(logic [CW-1:0] l);
    return (l == '0) ? 1 : int'(l);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(row_lrn == '0, req, 32'(row_lrn), 0);
    chk(lrn_mode == 1'b0, {req, " R10"}, 32'(lrn_mode), 0);
    chk(wl_en == '1, {req, " R6"}, 32'(wl_en), 32'(NR'('1)));
    chk(cset == '0 && crst == '0, req, 32'({cset, crst}), 0);
    chk(inf_ack == inf_vld, {req, " R9"}, 32'(inf_ack), 32'(inf_vld));
  endtask

  task automatic run_evt(input logic [AW-1:0] a, input logic neg, input logic [NR-1:0] el,
                         input logic [NC-1:0] tr, input logic [CW-1:0] l, input bit stray);
    logic hit;
    int n;
    @(negedge clk);
    upd_stb = 1'b1; upd_addr = a; upd_neg = neg; elig = el; trace = tr; plen = l;
    inf_vld = 1'($urandom);
    #1;
    chk(ack == 1'b0, "R3 ack one cycle", 32'(ack), 0);
    chk_idle("R1 idle before event");
    hit = el[a];
    n = eff_len(l);
    @(negedge clk);
    upd_stb = 1'b0;
    upd_neg = 1'($urandom); trace = NC'($urandom); elig = NR'($urandom); plen = CW'($urandom);
    if (!hit) begin
      #1;
      chk(ack == 1'b1, "R3 skip ack", 32'(ack), 1);
      chk_idle("R3 no write");
      return;
    end
    for (int k = 1; k <= n; k++) begin
      #1;
      chk(row_lrn == NR'(1) << a, "R2 row learn", 32'(row_lrn), 32'(NR'(1) << a));
      chk(lrn_mode == 1'b1, "R10 mode", 32'(lrn_mode), 1);
      chk(wl_en == NR'(1) << a, "R6 word lines", 32'(wl_en), 32'(NR'(1) << a));
      chk(cset == exp_set(tr, neg), "R4 R5 set", 32'(cset), 32'(exp_set(tr, neg)));
      chk(crst == exp_rst(tr, neg), "R4 R5 reset", 32'(crst), 32'(exp_rst(tr, neg)));
      chk(ack == 1'b0, "R7 no early ack", 32'(ack), 0);
      chk(inf_ack == 1'b0, "R9 inference dropped", 32'(inf_ack), 0);
      // R8: stray strobes during the write
      upd_stb = stray && (k < n) && 1'($urandom);
      upd_addr = AW'($urandom); elig = NR'($urandom); trace = NC'($urandom);
      upd_neg = 1'($urandom); inf_vld = 1'($urandom);
      @(negedge clk);
    end
    upd_stb = 1'b0;
    #1;
    chk(ack == 1'b1, "R7 end ack", 32'(ack), 1);
    chk_idle("R7 R8 back to idle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5a));
    repeat (2) @(negedge clk);
    #1;
    chk(ack == 1'b0, "R1 reset ack", 32'(ack), 0);
    chk_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk_idle("R1 after reset");
    // directed
    run_evt(AW'(3), 1'b0, 8'hFF, 8'hA5, CW'(3), 1'b0);
    run_evt(AW'(3), 1'b1, 8'hFF, 8'h5A, CW'(2), 1'b0);
    run_evt(AW'(7), 1'b0, 8'h80, 8'hFF, CW'(0), 1'b0);
    run_evt(AW'(0), 1'b1, 8'h01, 8'h00, CW'(1), 1'b0);
    run_evt(AW'(5), 1'b0, 8'hDF, 8'hFF, CW'(4), 1'b0);
    run_evt(AW'(5), 1'b0, 8'hDF, 8'hFF, CW'(4), 1'b0);
    run_evt(AW'(2), 1'b1, 8'h04, 8'hC3, CW'(6), 1'b1);
    // random
    for (int i = 0; i < 300; i++)
      run_evt(AW'($urandom), 1'($urandom), NR'($urandom), NC'($urandom),
              CW'($urandom_range(0, 12)), 1'b1);
    @(negedge clk);
    #1;
    chk(ack == 1'b0, "R3 R7 ack drops", 32'(ack), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule